// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit carries out one atomic operation at a time against a synchronous, doubleword-wide memory port. A request names the operation, a byte address, a source operand and an access size (32-bit word or 64-bit doubleword). For the read-modify-write operations the unit first reads the addressed location. It then returns the value it read on the result output and stores a combination of that value and the operand back to the same place. The combinations are swap, add, xor, or, and, and signed or unsigned minimum and maximum.

Two further operations form a load-reserved / store-conditional pair. They share a single reservation register. A load-reserved reads memory and records the address. A store-conditional writes only when its address matches a live reservation, and it reports success as 0 and failure as 1. Every request finishes with a one-cycle `done` pulse. The result stays on `rdOut` until the next request completes. The memory port reads synchronously: data appears on `memRdata` in the cycle after `memRe`.

Top module: `amo_unit`

## Requirements
- R1: Every read-modify-write operation returns on `rdOut` the contents that memory held at the addressed location before the operation. For a word access this value is sign-extended to 64 bits.
- R2: The write-back value is chosen by `op`. Code 0 stores the operand (swap), 1 stores the sum, 2 the xor, 3 the or, and 4 the and of the operand and the old value.
- R3: Codes 5 and 6 store the smaller and the larger of the operand and the old value, compared as two's-complement numbers. Codes 7 and 8 do the same with an unsigned comparison.
- R4: Load-reserved (code 9) returns the sign-extended memory value, leaves memory unchanged and reserves the request address.
- R5: Store-conditional (code 10) writes the operand and returns 0 only when a reservation is live and its address equals the request address. Otherwise memory is untouched and the result is 1.
- R6: With `isDouble`=1 an access covers all 64 bits of the line. With `isDouble`=0 it covers the 32-bit half selected by address bit 2 (0 = bits 31:0, 1 = bits 63:32), and the other half keeps its contents.
- R7: Any store-conditional, whether it succeeds or fails, leaves no reservation behind.
- R8: A read-modify-write to the reserved address cancels the reservation. One to any other address keeps it.
- R9: Counting clock edges from the edge that accepts `start`, `done` is high for exactly one cycle. It rises after 4 edges for a read-modify-write, after 3 for a load-reserved, after 2 for a successful store-conditional and after 1 for a failed one. The memory write, when there is one, is issued in the cycle just before `done`.
- R10: A `start` raised while `busy` is high has no effect on memory, on the reservation or on the running operation.
- R11: After reset the unit is idle, with `done`, `busy`, `memRe` and `memWe` low, and no reservation is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only while idle |
| op | input | 4 | Operation code (see R2 to R5) |
| isDouble | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| addr | input | ADDR_W | Byte address of the access |
| rs2 | input | 64 | Source operand |
| rdOut | output | 64 | Result of the last completed request |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while a request is in progress |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W-3 | Doubleword line address |
| memWmask | output | 2 | Write enable per 32-bit half, bit 1 = upper |
| memWdata | output | 64 | Write data, word data repeated in both halves |
| memRdata | input | 64 | Read data, valid the cycle after memRe |

## Verification
A corrupted reservation shows up at the next store-conditional. Its result code flips, and its `done` moves by one cycle, because a successful conditional store takes an extra write cycle. A wrong compare sign or a wrong half select leaves a bad value in memory, and this surfaces as a wrong old value the next time that location is touched. The reference memory image is compared against the bench memory in the `done` cycle of every request, so such damage is caught within that request. A state machine that skips or repeats a step moves `done` off its expected cycle, and this is detected on that same clock.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [3:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_XOR  = 4'd2,
    OP_OR   = 4'd3,
    OP_AND  = 4'd4,
    OP_MIN  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MINU = 4'd7,
    OP_MAXU = 4'd8,
    OP_LR   = 4'd9,
    OP_SC   = 4'd10
  } amoOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CALC,
    ST_WRITE,
    ST_FINISH
  } amoState_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic accept;
    logic memRd;
    logic capture;
    logic memWr;
    logic setRes;
    logic clrRes;
  } amoCtl_t;

  // merge the operand (b) into the old memory value (a)
  function automatic logic [63:0] amoCombine(input logic [3:0] op,
                                             input logic [63:0] a,
                                             input logic [63:0] b);
    logic [63:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_XOR:  r = a ^ b;
      OP_OR:   r = a | b;
      OP_AND:  r = a & b;
      OP_MIN:  r = ($signed(a) < $signed(b)) ? a : b;
      OP_MAX:  r = ($signed(a) < $signed(b)) ? b : a;
      OP_MINU: r = (a < b) ? a : b;
      OP_MAXU: r = (a < b) ? b : a;
      default: r = b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] opIn,
  input  logic [3:0] reqOp,
  input  logic       resHit,
  output amoCtl_t    ctl,
  output logic       busy,
  output logic       done
);

  amoState_e state, stateNext;
  logic      accept;

  assign accept = (state == ST_IDLE) && start;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (opIn == OP_SC) stateNext = resHit ? ST_WRITE : ST_FINISH;
          else               stateNext = ST_READ;
        end
      end
      ST_READ:   stateNext = ST_CALC;
      ST_CALC:   stateNext = (reqOp == OP_LR) ? ST_FINISH : ST_WRITE;
      ST_WRITE:  stateNext = ST_FINISH;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.accept  = accept;
    ctl.memRd   = (state == ST_READ);
    ctl.capture = (state == ST_CALC);
    ctl.memWr   = (state == ST_WRITE);
    ctl.setRes  = accept && (opIn == OP_LR);
    ctl.clrRes  = accept && ((opIn == OP_SC) || ((opIn != OP_LR) && resHit));
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

endmodule

// File: rtl/amo_datapath.sv
module amo_datapath
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  localparam int LINE_AW = ADDR_W - 3,
  localparam int HALF_W  = DATA_W / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  amoCtl_t            ctl,
  input  logic [3:0]         opIn,
  input  logic               isDoubleIn,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic [DATA_W-1:0]  rs2In,
  input  logic [DATA_W-1:0]  memRdata,
  output logic [3:0]         reqOp,
  output logic               resHit,
  output logic               resValid,
  output logic               memRe,
  output logic               memWe,
  output logic [LINE_AW-1:0] memAddr,
  output logic [1:0]         memWmask,
  output logic [DATA_W-1:0]  memWdata,
  output logic [DATA_W-1:0]  rdOut
);

  logic              reqDbl;
  logic [ADDR_W-1:2] reqAddr;
  logic [DATA_W-1:0] reqData;
  logic [ADDR_W-1:0] resAddr;
  logic [DATA_W-1:0] rdQ, newVal;

  logic [HALF_W-1:0] oldHalf, rs2Half;
  logic [DATA_W-1:0] loadExt, opA, opB, wSrc;
  logic              signedCmp;

  assign resHit = resValid && (resAddr == addrIn);

  // pick the addressed half and widen the operands for a word access
  always_comb begin
    oldHalf   = reqAddr[2] ? memRdata[DATA_W-1:HALF_W] : memRdata[HALF_W-1:0];
    rs2Half   = reqData[HALF_W-1:0];
    signedCmp = !((reqOp == OP_MINU) || (reqOp == OP_MAXU));
    loadExt   = reqDbl ? memRdata : {{HALF_W{oldHalf[HALF_W-1]}}, oldHalf};
    opA       = reqDbl ? memRdata : {{HALF_W{signedCmp & oldHalf[HALF_W-1]}}, oldHalf};
    opB       = reqDbl ? reqData  : {{HALF_W{signedCmp & rs2Half[HALF_W-1]}}, rs2Half};
    wSrc      = (reqOp == OP_SC) ? reqData : newVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqOp    <= '0;
      reqDbl   <= 1'b0;
      reqAddr  <= '0;
      reqData  <= '0;
      resValid <= 1'b0;
      resAddr  <= '0;
      rdQ      <= '0;
      newVal   <= '0;
    end else begin
      if (ctl.accept) begin
        reqOp   <= opIn;
        reqDbl  <= isDoubleIn;
        reqAddr <= addrIn[ADDR_W-1:2];
        reqData <= rs2In;
        if (opIn == OP_SC) rdQ <= resHit ? '0 : DATA_W'(1);
      end
      if (ctl.clrRes) resValid <= 1'b0;
      if (ctl.setRes) begin
        resValid <= 1'b1;
        resAddr  <= addrIn;
      end
      if (ctl.capture) begin
        rdQ    <= loadExt;
        newVal <= amoCombine(reqOp, opA, opB);
      end
    end
  end

  assign memRe    = ctl.memRd;
  assign memWe    = ctl.memWr;
  assign memAddr  = reqAddr[ADDR_W-1:3];
  assign memWmask = reqDbl ? 2'b11 : (reqAddr[2] ? 2'b10 : 2'b01);
  assign memWdata = reqDbl ? wSrc : {wSrc[HALF_W-1:0], wSrc[HALF_W-1:0]};
  assign rdOut    = rdQ;

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic              isDouble,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       rs2,
  output logic [63:0]       rdOut,
  output logic              done,
  output logic              busy,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-4:0] memAddr,
  output logic [1:0]        memWmask,
  output logic [63:0]       memWdata,
  input  logic [63:0]       memRdata
);

  amoCtl_t    ctl;
  logic [3:0] reqOp;
  logic       resHit;
  logic       resValid;

  amo_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opIn   (op),
    .reqOp  (reqOp),
    .resHit (resHit),
    .ctl    (ctl),
    .busy   (busy),
    .done   (done)
  );

  amo_datapath #(.ADDR_W(ADDR_W), .DATA_W(64)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .opIn       (op),
    .isDoubleIn (isDouble),
    .addrIn     (addr),
    .rs2In      (rs2),
    .memRdata   (memRdata),
    .reqOp      (reqOp),
    .resHit     (resHit),
    .resValid   (resValid),
    .memRe      (memRe),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWmask   (memWmask),
    .memWdata   (memWdata),
    .rdOut      (rdOut)
  );

endmodule

// File: rtl/amo_checker.sv
module amo_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [3:0] op,
  input logic       busy,
  input logic       done,
  input logic       memRe,
  input logic       memWe,
  input logic       resHit,
  input logic       resValid
);

  AST_SC_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && op == 4'd10 && !resHit) |=> (done && !memWe)); // R5

  AST_SC_DROPS_RES: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && op == 4'd10) |=> !resValid); // R7

  AST_RMW_DROPS_RES: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && op != 4'd9 && op != 4'd10 && resHit) |=> !resValid); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_WRITE_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> done); // R9

  AST_READ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && op != 4'd10) |=> memRe); // R9

  AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> busy); // R10

endmodule

bind amo_unit amo_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .op       (op),
  .busy     (busy),
  .done     (done),
  .memRe    (memRe),
  .memWe    (memWe),
  .resHit   (resHit),
  .resValid (resValid)
);

// File: tb/sim_amo_unit.sv
module sim_amo_unit;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    op = '0;
  logic          isDouble = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [63:0]   rs2 = '0;
  logic [63:0]   rdOut;
  logic          done, busy, memRe, memWe;
  logic [AW-4:0] memAddr;
  logic [1:0]    memWmask;
  logic [63:0]   memWdata;
  logic [63:0]   memRdata;

  logic [63:0] mem   [0:31];
  logic [63:0] model [0:31];
  bit          mResV = 0;
  logic [AW-1:0] mResA = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  amo_unit #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .isDouble(isDouble),
    .addr(addr), .rs2(rs2), .rdOut(rdOut), .done(done), .busy(busy),
    .memRe(memRe), .memWe(memWe), .memAddr(memAddr), .memWmask(memWmask),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [63:0] seedVal(int i);
    return (64'h0123456789ABCDEF * (i + 1)) ^ {32'(i), 32'hA5A50000};
  endfunction

  // behavioural memory with a one-cycle read
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mem[i] <= seedVal(i);
      memRdata <= '0;
    end else begin
      if (memRe) memRdata <= mem[memAddr[4:0]];
      if (memWe) begin
        if (memWmask[0]) mem[memAddr[4:0]][31:0]  <= memWdata[31:0];
        if (memWmask[1]) mem[memAddr[4:0]][63:32] <= memWdata[63:32];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] calc64(int o, logic [63:0] a, logic [63:0] b);
    longint sa = a, sb = b;
    case (o)
      0: return b;
      1: return a + b;
      2: return a ^ b;
      3: return a | b;
      4: return a & b;
      5: return (sa < sb) ? a : b;
      6: return (sa > sb) ? a : b;
      7: return (a < b) ? a : b;
      default: return (a > b) ? a : b;
    endcase
  endfunction

  function automatic logic [31:0] calc32(int o, logic [31:0] a, logic [31:0] b);
    int sa = a, sb = b;
    case (o)
      0: return b;
      1: return a + b;
      2: return a ^ b;
      3: return a | b;
      4: return a & b;
      5: return (sa < sb) ? a : b;
      6: return (sa > sb) ? a : b;
      7: return (a < b) ? a : b;
      default: return (a > b) ? a : b;
    endcase
  endfunction

  // reference model: latency, expected result, memory and reservation update
  task automatic modelOp(input int o, input bit dbl, input logic [AW-1:0] a,
                         input logic [63:0] d, output int lat, output logic [63:0] expRd);
    int idx = int'(a[7:3]);
    logic [63:0] line = model[idx];
    logic [31:0] half = a[2] ? line[63:32] : line[31:0];
    logic [63:0] oldExt = dbl ? line : {{32{half[31]}}, half};
    if (o == 9) begin
      expRd = oldExt; lat = 3; mResV = 1; mResA = a;
    end else if (o == 10) begin
      if (mResV && mResA == a) begin
        expRd = 0; lat = 2;
        if (dbl) model[idx] = d;
        else if (a[2]) model[idx][63:32] = d[31:0];
        else model[idx][31:0] = d[31:0];
      end else begin
        expRd = 1; lat = 1;
      end
      mResV = 0;
    end else begin
      expRd = oldExt; lat = 4;
      if (dbl) model[idx] = calc64(o, line, d);
      else if (a[2]) model[idx][63:32] = calc32(o, half, d[31:0]);
      else model[idx][31:0] = calc32(o, half, d[31:0]);
      if (mResV && mResA == a) mResV = 0;
    end
  endtask

  task automatic doOp(input int o, input bit dbl, input logic [AW-1:0] a,
                      input logic [63:0] d, input string req,
                      input bit poke = 0, input logic [AW-1:0] pokeAddr = '0);
    int lat;
    logic [63:0] expRd;
    int bad;
    while (busy) @(negedge clk);
    modelOp(o, dbl, a, d, lat, expRd);
    start = 1; op = 4'(o); isDouble = dbl; addr = a; rs2 = d;
    @(negedge clk);
    start = 0; op = 4'd1; addr = '1; rs2 = 64'hDEADBEEFCAFEF00D;
    for (int c = 1; c <= lat; c++) begin
      if (c > 1) @(negedge clk);
      if (poke && c == 1) begin
        start = 1; op = 4'd0; isDouble = 1; addr = pokeAddr; rs2 = 64'h5A5A5A5A5A5A5A5A;
      end
      if (poke && c == 2) start = 0;
      check(done == (c == lat), req, $sformatf("done in cycle %0d", c), 64'(done), 64'(c == lat));
    end
    check(rdOut == expRd, req, "result", rdOut, expRd);
    bad = 0;
    for (int i = 0; i < 32; i++) if (mem[i] !== model[i]) bad++;
    check(bad == 0, req, "memory image mismatches", 64'(bad), 64'd0);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = seedVal(i);
    repeat (3) @(negedge clk);
    // R11: outputs idle during and after reset
    check(!done && !busy, "R11", "done/busy in reset", {62'd0, done, busy}, 64'd0);
    rstN = 1;
    @(negedge clk);
    check(!done && !busy && !memRe && !memWe, "R11", "idle after reset",
          {60'd0, done, busy, memRe, memWe}, 64'd0);
    doOp(10, 1, 16'h0010, 64'h1, "R11");                      // no reservation after reset

    // R1 R2: doubleword merges
    doOp(0, 1, 16'h0008, 64'h1122334455667788, "R1");
    doOp(1, 1, 16'h0008, 64'h00000000000000F5, "R2");
    doOp(2, 1, 16'h0008, 64'hFF00FF00FF00FF00, "R2");
    doOp(3, 1, 16'h0008, 64'h0000000F0000000F, "R2");
    doOp(4, 1, 16'h0008, 64'hF0F0F0F0F0F0F0F0, "R2");

    // R6: word halves and sign extension
    doOp(0, 0, 16'h0020, 64'h0000000080000001, "R6");
    doOp(0, 0, 16'h0024, 64'h000000007FFFFFFF, "R6");
    doOp(9, 0, 16'h0020, 64'h0, "R4");
    doOp(9, 0, 16'h0024, 64'h0, "R6");

    // R3: signed versus unsigned compare, word
    doOp(5, 0, 16'h0020, 64'h5, "R3");
    doOp(7, 0, 16'h0024, 64'h5, "R3");
    doOp(6, 0, 16'h0020, 64'hFFFFFFFF, "R3");
    doOp(8, 0, 16'h0024, 64'h80000000, "R3");

    // R3: doubleword compares
    doOp(0, 1, 16'h0030, 64'hFFFFFFFFFFFFFFFD, "R3");
    doOp(5, 1, 16'h0030, 64'h7, "R3");
    doOp(8, 1, 16'h0030, 64'h7, "R3");
    doOp(7, 1, 16'h0030, 64'h7, "R3");
    doOp(6, 1, 16'h0030, 64'hFFFFFFFFFFFFFFF7, "R3");

    // R6: word add wraps within its half
    doOp(0, 0, 16'h0040, 64'hFFFFFFFF, "R6");
    doOp(1, 0, 16'h0040, 64'h2, "R6");

    // R4 R5 R7: reservation pair
    doOp(9, 1, 16'h0050, 64'h0, "R4");
    doOp(10, 1, 16'h0050, 64'h0BADC0DE0BADC0DE, "R5");
    doOp(10, 1, 16'h0050, 64'h1111111111111111, "R7");
    doOp(9, 1, 16'h0058, 64'h0, "R4");
    doOp(10, 1, 16'h0060, 64'h2222, "R5");
    doOp(10, 1, 16'h0058, 64'h3333, "R7");
    doOp(9, 0, 16'h0064, 64'h0, "R4");
    doOp(10, 0, 16'h0064, 64'h00000000ABCD1234, "R5");

    // R8: other-address merge keeps, same-address merge cancels
    doOp(9, 1, 16'h0068, 64'h0, "R8");
    doOp(1, 1, 16'h0070, 64'h10, "R8");
    doOp(10, 1, 16'h0068, 64'h4444, "R8");
    doOp(9, 1, 16'h0068, 64'h0, "R8");
    doOp(0, 1, 16'h0068, 64'h5555, "R8");
    doOp(10, 1, 16'h0068, 64'h6666, "R8");

    // R10: start while busy is ignored (memory image covers the poked line)
    doOp(1, 1, 16'h0078, 64'h3, "R10", 1, 16'h0080);
    doOp(9, 1, 16'h0088, 64'h0, "R10");
    doOp(1, 1, 16'h0090, 64'h3, "R10", 1, 16'h0088);
    doOp(10, 1, 16'h0088, 64'h7777, "R10");
    doOp(9, 1, 16'h0098, 64'h0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule